// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive request lines and hands one winner to a processor core. The winner is given as a priority level plus a vector number. Each source carries a programmable 8-bit level. A zero level also turns the source off. Among live sources the highest level wins, and on a tie the larger source index wins. The vector is the winning index plus 64. When nothing is live, the vector is the spurious value 24 and the level is 0.

Software reaches the controller over a simple 32-bit register bus that decodes a 256-byte window. The window provides:
- a read-only view of the request lines, as two 32-bit words;
- a 64-bit mask, as two words;
- a 64-bit force word pair that raises sources from software;
- one level byte per source;
- byte-wide commands that set or clear one mask bit by index;
- a read-only port that returns the current vector.

Both outputs are registered. They follow any change one clock after the register that holds it has updated.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Bit n of the pending register copies `irq_in[n]` on every clock edge. Pending bits 63:32 read at offset 0x00 and bits 31:0 read at offset 0x04. Writes to 0x00 and 0x04 change nothing.
- R2: Source n is live only when (pending[n] OR force[n]) AND enable[n] AND NOT mask[n].
- R3: The level byte of source n is written from data bits 7:0 at offset 0x40+n and reads back there in bits 7:0. A nonzero write sets enable[n] and a zero write clears it.
- R4: Among live sources the one with the largest level byte wins. Among equal levels the larger index wins.
- R5: `irq_vector` equals the winning index plus 64 and `irq_level` equals its level byte. With no live source, `irq_vector` is 24 and `irq_level` is 0.
- R6: The mask word at 0x08 holds bits 63:32 and the word at 0x0C holds bits 31:0. Writing one word leaves the other unchanged. A mask bit of 1 blocks its source.
- R7: A write to 0x1C sets the mask bit indexed by data bits 5:0. A write to 0x1D clears the mask bit indexed by data bits 5:0.
- R8: The force word at 0x10 holds bits 63:32 and the word at 0x14 holds bits 31:0. Both are writable and read back.
- R9: A read of 0xE0 returns the current `irq_vector` in bits 7:0. Unmapped offsets read as zero.
- R10: After a synchronous reset, every level byte and enable bit is 0, the mask is all ones, force is 0, `irq_vector` is 24 and `irq_level` is 0.
- R11: A write issued on edge E is reflected in the outputs from edge E+1 on. An `irq_in` change sampled on edge E is also reflected from edge E+1. Read data appears on the edge after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive request lines |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq_level | output | 8 | Level byte of the winning source, 0 if none |
| irq_vector | output | 8 | Winning index plus 64, or 24 if none |

## Verification
The bench sets up ties at equal levels. A scan that used a strict compare would then hand the vector to the lower index instead of the higher one. It writes a zero level to a requesting, unmasked source. A design that kept the enable would go on asserting that source. It writes one mask half and reads the other back, which catches a full-word overwrite. It also drives the set- and clear-mask commands with data whose upper bits are nonzero, which catches a design that decodes more than six index bits. Random mixes of line toggles, forces and level writes are compared after every step against a bench model of the arbitration, including the spurious 24 case when every source is blocked.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [7:0] OFS_PEND_HI  = 8'h00;
  localparam logic [7:0] OFS_PEND_LO  = 8'h04;
  localparam logic [7:0] OFS_MASK_HI  = 8'h08;
  localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFS_FORCE_HI = 8'h10;
  localparam logic [7:0] OFS_FORCE_LO = 8'h14;
  localparam logic [7:0] OFS_MSET     = 8'h1C;
  localparam logic [7:0] OFS_MCLR     = 8'h1D;
  localparam logic [7:0] OFS_LVL_BASE = 8'h40;
  localparam logic [7:0] OFS_VEC_RD   = 8'hE0;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8,
  parameter int VEC_W  = 8,
  localparam int NSRC  = 2 * DATA_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [VEC_W-1:0]  cur_vec,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   frc,
  output logic [NSRC-1:0]   en,
  output logic [LVL_W-1:0]  lvl [NSRC]
);
  import prio_irq_pkg::*;

  logic             lvl_hit;
  logic [IDX_W-1:0] lvl_idx;
  logic [IDX_W-1:0] cmd_idx;

  assign lvl_hit = (bus_addr >= OFS_LVL_BASE) &&
                   ({1'b0, bus_addr} < ({1'b0, OFS_LVL_BASE} + 9'(NSRC)));
  assign lvl_idx = bus_addr[IDX_W-1:0];
  assign cmd_idx = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      frc  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_MASK_HI:  mask[NSRC-1:DATA_W] <= bus_wdata;
        OFS_MASK_LO:  mask[DATA_W-1:0]    <= bus_wdata;
        OFS_FORCE_HI: frc[NSRC-1:DATA_W]  <= bus_wdata;
        OFS_FORCE_LO: frc[DATA_W-1:0]     <= bus_wdata;
        OFS_MSET:     mask[cmd_idx]       <= 1'b1;
        OFS_MCLR:     mask[cmd_idx]       <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl[g] <= '0;
        en[g]  <= 1'b0;
      end else if (bus_we && lvl_hit && lvl_idx == IDX_W'(g)) begin
        lvl[g] <= bus_wdata[LVL_W-1:0];
        en[g]  <= |bus_wdata[LVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      bus_rdata <= '0;
      if (lvl_hit) bus_rdata <= DATA_W'(lvl[lvl_idx]);
      else begin
        case (bus_addr)
          OFS_PEND_HI:  bus_rdata <= pend[NSRC-1:DATA_W];
          OFS_PEND_LO:  bus_rdata <= pend[DATA_W-1:0];
          OFS_MASK_HI:  bus_rdata <= mask[NSRC-1:DATA_W];
          OFS_MASK_LO:  bus_rdata <= mask[DATA_W-1:0];
          OFS_FORCE_HI: bus_rdata <= frc[NSRC-1:DATA_W];
          OFS_FORCE_LO: bus_rdata <= frc[DATA_W-1:0];
          OFS_VEC_RD:   bus_rdata <= DATA_W'(cur_vec);
          default:      bus_rdata <= '0;
        endcase
      end
    end
  end

  // R1: pending is a straight copy of the lines, whatever the bus does
  a_r1_pend_copy: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend == $past(irq_in));
  // R6: a write to the high mask word keeps the low word
  a_r6_mask_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MASK_HI) |=> mask[DATA_W-1:0] == $past(mask[DATA_W-1:0]));
  // R6: a write to the low mask word keeps the high word
  a_r6_mask_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MASK_LO) |=> mask[NSRC-1:DATA_W] == $past(mask[NSRC-1:DATA_W]));
  // R7: set-mask by index
  a_r7_mset: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MSET) |=> mask[$past(cmd_idx)]);
  // R7: clear-mask by index
  a_r7_mclr: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MCLR) |=> !mask[$past(cmd_idx)]);
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NSRC  = 64,
  parameter int LVL_W = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  active,
  input  logic [LVL_W-1:0] lvl [NSRC],
  output logic             win_vld,
  output logic [LVL_W-1:0] win_lvl,
  output logic [IDX_W-1:0] win_idx
);
  // Ascending scan with a greater-or-equal compare: the last of the
  // highest-level sources in index order ends up holding the slot.
  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!win_vld || lvl[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_lvl = lvl[i];
        win_idx = IDX_W'(i);
      end
    end
  end

  // R4: the chosen source is among the live ones
  a_r4_winner_live: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> active[win_idx]);
  // R5: a winner exists exactly when some source is live
  a_r5_any_live: assert property (@(posedge clk) disable iff (rst)
    win_vld == (|active));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int DATA_W   = 32,
  parameter int LVL_W    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  localparam int NSRC    = 2 * DATA_W,
  localparam int IDX_W   = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [NSRC-1:0]  pend, mask, frc, en, active;
  logic [LVL_W-1:0] lvl [NSRC];
  logic             win_vld;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;

  irq_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cur_vec(irq_vector), .bus_rdata(bus_rdata),
    .pend(pend), .mask(mask), .frc(frc), .en(en), .lvl(lvl)
  );

  assign active = (pend | frc) & en & ~mask;

  irq_arb #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .active(active), .lvl(lvl),
    .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level  <= '0;
      irq_vector <= VEC_W'(VEC_SPUR);
    end else if (win_vld) begin
      irq_level  <= win_lvl;
      irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end else begin
      irq_level  <= '0;
      irq_vector <= VEC_W'(VEC_SPUR);
    end
  end

  // R10: first cycle out of reset shows the idle outputs
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_vector == VEC_W'(VEC_SPUR) && irq_level == '0));
  // R5: zero level goes with the spurious vector and nothing else
  a_r5_spur_pair: assert property (@(posedge clk) disable iff (rst)
    (irq_level == '0) == (irq_vector == VEC_W'(VEC_SPUR)));
  // R5: a real vector lies in the source range
  a_r5_vec_range: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE) &&
                           irq_vector <  VEC_W'(VEC_BASE + NSRC)));
  // R3: a live source never carries a zero level, so a winner shows nonzero
  a_r3_live_nonzero: assert property (@(posedge clk) disable iff (rst)
    (|active) |=> irq_level != '0);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] irq_in;
  logic        bus_we, bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_level, irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_lvl [64];
  logic [63:0] m_mask, m_frc, m_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  function automatic logic [15:0] ref_out();
    logic [63:0] act;
    logic [7:0]  bl, bv;
    logic        found;
    act = 64'd0;
    for (int i = 0; i < 64; i++)
      act[i] = (m_in[i] | m_frc[i]) & (m_lvl[i] != 8'd0) & ~m_mask[i];
    bl = 8'd0; bv = 8'd24; found = 1'b0;
    for (int i = 0; i < 64; i++)
      if (act[i] && (!found || m_lvl[i] >= bl)) begin
        found = 1'b1; bl = m_lvl[i]; bv = 8'(64 + i);
      end
    return {bl, bv};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    logic [15:0] e;
    e = ref_out();
    chk({req, " level"}, 64'(irq_level), 64'(e[15:8]));
    chk({req, " vector"}, 64'(irq_vector), 64'(e[7:0]));
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h08) m_mask[63:32] = d;
    else if (a == 8'h0C) m_mask[31:0] = d;
    else if (a == 8'h10) m_frc[63:32] = d;
    else if (a == 8'h14) m_frc[31:0] = d;
    else if (a == 8'h1C) m_mask[d[5:0]] = 1'b1;
    else if (a == 8'h1D) m_mask[d[5:0]] = 1'b0;
    else if (a >= 8'h40 && a < 8'h80) m_lvl[a[5:0]] = d[7:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive_in(input logic [63:0] v);
    irq_in = v; m_in = v;
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst = 1'b1; irq_in = '0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    m_in = '0; m_frc = '0; m_mask = '1;
    for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    chk("R10 level", 64'(irq_level), 64'd0);
    chk("R10 vector", 64'(irq_vector), 64'd24);
    rd(8'h08, r); chk("R10 mask hi", 64'(r), 64'hFFFFFFFF);
    rd(8'h14, r); chk("R10 force lo", 64'(r), 64'd0);
    rd(8'h7F, r); chk("R10 level byte 63", 64'(r), 64'd0);
    rd(8'hE0, r); chk("R9 vector read idle", 64'(r), 64'd24);

    // R2 masked requests stay idle
    drive_in(64'h0000_0000_0000_0020);
    wr(8'h45, 32'h3); settle(); chk_out("R2 masked");
    // R6 half writes
    wr(8'h0C, 32'h0); settle(); chk_out("R5 single source");
    chk("R5 vec 69", 64'(irq_vector), 64'd69);
    rd(8'h08, r); chk("R6 hi kept", 64'(r), 64'hFFFFFFFF);
    wr(8'h08, 32'h0); settle();
    rd(8'h0C, r); chk("R6 lo kept", 64'(r), 64'd0);
    // R4 tie goes to larger index
    drive_in(64'h0000_0000_0000_0420);
    wr(8'h4A, 32'h3); settle(); chk_out("R4 tie");
    chk("R4 tie vec 74", 64'(irq_vector), 64'd74);
    // R4 higher level wins over larger index
    drive_in(64'h0000_0000_0000_0428);
    wr(8'h43, 32'hFFFF_FF07); settle(); chk_out("R4 level");
    chk("R4 vec 67", 64'(irq_vector), 64'd67);
    rd(8'h43, r); chk("R3 level readback", 64'(r), 64'd7);
    rd(8'hE0, r); chk("R9 vector read", 64'(r), 64'd67);
    // R3 zero level disables
    wr(8'h43, 32'h0); settle(); chk_out("R3 zero disables");
    chk("R3 vec 74", 64'(irq_vector), 64'd74);
    // R8 force without line
    wr(8'h7E, 32'h9); wr(8'h10, 32'h4000_0000); settle(); chk_out("R8 force");
    chk("R8 vec 126", 64'(irq_vector), 64'd126);
    rd(8'h10, r); chk("R8 force readback", 64'(r), 64'h4000_0000);
    // R7 set/clear with upper data bits nonzero
    wr(8'h1C, 32'hFFFF_FF7E); settle(); chk_out("R7 set mask");
    rd(8'h08, r); chk("R7 set bit 62", 64'(r), 64'h4000_0000);
    wr(8'h1D, 32'h0000_00FE); settle(); chk_out("R7 clear mask");
    rd(8'h08, r); chk("R7 clear bit 62", 64'(r), 64'd0);
    // R1 pending readback, writes ignored
    drive_in(64'h8000_0001_0000_0428);
    wr(8'h00, 32'h0); wr(8'h04, 32'hFFFF_FFFF); settle();
    rd(8'h00, r); chk("R1 pend hi", 64'(r), 64'h8000_0001);
    rd(8'h04, r); chk("R1 pend lo", 64'(r), 64'h0000_0428);
    rd(8'h20, r); chk("R9 unmapped", 64'(r), 64'd0);
    // R11 timing: write on edge E visible from E+1, not before
    wr(8'h4A, 32'h20);
    chk("R11 not yet", 64'(irq_vector), 64'd126);
    @(posedge clk); @(negedge clk); chk_out("R11 one edge");
    // R2 everything blocked -> spurious
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); settle();
    chk_out("R5 spurious"); chk("R5 vec 24", 64'(irq_vector), 64'd24);
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: drive_in({$urandom(), $urandom()});
        2, 3, 4: wr(8'(8'h40 + $urandom_range(0, 63)),
                    ($urandom_range(0, 7) == 0) ? 32'h0 : 32'($urandom_range(1, 4)));
        5: wr(($urandom_range(0, 1) != 0) ? 8'h08 : 8'h0C, $urandom() & $urandom());
        6: wr(8'h1C, $urandom());
        7: wr(8'h1D, $urandom());
        8: wr(($urandom_range(0, 1) != 0) ? 8'h10 : 8'h14, $urandom() & $urandom() & $urandom());
        default: wr(8'h00, $urandom());
      endcase
      settle();
      chk_out("R2 R4 R5 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule